// File: doc/BRIEF.md
# Serial Interface Interrupt Flag Register

This block holds the interrupt status word of a four-line serial flash host controller. Single-cycle event strobes and level conditions come in from the serializer and the data-register logic. The block keeps six flags that software reads over a simple register port. The same port clears the event-type flags by writing a one to them. A registered, active-high interrupt request is the OR of every flag masked by a companion enable word.

The flags are of two kinds. Three are sticky event flags: end of instruction, chip-select deassertion and receive overrun. These are set by hardware and cleared by software. The other three follow data-path state, and software writes do not reach them. Receive-full tracks whether the receive holding register holds unread data. Transmit-empty tracks whether a written transmit word is still waiting for the shifter. Transfer-complete tracks whether everything has left the shifter and a programmable guard delay of 0 to 255 cycles has run out.

Flags change on the clock edge that samples their cause. They are visible on the read port in the cycle after that edge, and the interrupt follows one cycle later. No input of this block uses valid/ready handshaking and none applies back-pressure. All strobes are plain one-cycle pulses, and the register port accepts a write in every cycle.

Top module: `sif_intflag`

## Requirements
- R1: After reset every flag reads 0 and `irq` is 0.
- R2: A read at offset 0x1C returns end-of-instruction on bit 10, chip-select rise on bit 8, overrun on bit 3, transfer-complete on bit 2, transmit-empty on bit 1 and receive-full on bit 0. All other bits read 0, and a read at any other offset returns 0.
- R3: A pulse on `ev_instr_end` or `ev_cs_rise` sets bit 10 or bit 8 respectively. Writing 1 to that bit at offset 0x1C clears it, and writing 0 leaves it set.
- R4: When a set event and a write-one-clear hit the same event flag in the same cycle, the flag ends up set.
- R5: `rx_load` sets bit 0 and `rx_read` clears it. When both occur in the same cycle, bit 0 ends up set.
- R6: Bit 3 sets when `rx_load` arrives while bit 0 is already set and `rx_read` is not asserted in that cycle. Writing 1 to bit 3 clears it.
- R7: Bit 1 is 0 while `ctl_enable` is low. It becomes 1 one cycle after enable goes high, drops to 0 after an enabled `tx_write`, and returns to 1 after `tx_to_shift`.
- R8: Bit 2 drops to 0 after an enabled `tx_write`. It becomes 1 when no word is pending and `shift_empty` has been high for `cfg_xfer_dly` cycles after its rising edge. With a delay of 0 it is set on the rising edge itself.
- R9: Writes to bits 2, 1 and 0 have no effect on those flags.
- R10: `irq` equals, one cycle later, the OR over all bits of the flag word ANDed with `irq_en`.
- R11: A write to any offset other than 0x1C leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; a 1 clears the matching event flag |
| bus_rdata | output | 32 | Read data for the current offset |
| irq_en | input | 32 | Interrupt enable mask, aligned with the flag bits |
| ctl_enable | input | 1 | Controller enable level |
| cfg_xfer_dly | input | DLY_W | Guard delay in cycles before transfer-complete |
| ev_instr_end | input | 1 | Pulse: instruction finished |
| ev_cs_rise | input | 1 | Pulse: chip select deasserted |
| rx_load | input | 1 | Pulse: serializer loaded the receive register |
| rx_read | input | 1 | Pulse: software read the receive register |
| tx_write | input | 1 | Pulse: software wrote the transmit register |
| tx_to_shift | input | 1 | Pulse: transmit word moved into the shifter |
| shift_empty | input | 1 | Level: shifter holds no data |
| irq | output | 1 | Registered interrupt request |

## Verification
The properties assume that every event input is a single-cycle strobe sampled on the rising clock edge. They also assume that `shift_empty` falls no later than the cycle of the `tx_to_shift` that loads the shifter. The bench drives all inputs on the falling edge and raises each strobe for exactly one cycle. It changes `shift_empty` only together with, or after, the transfer it belongs to. Scenarios where two causes meet in one cycle (set against clear, load against read) are arranged on purpose, so that both priority rules are exercised.

// File: rtl/sif_intflag_pkg.sv
package sif_intflag_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned NUM_EVT     = 3;
  localparam int unsigned POS_INSTEND = 10;
  localparam int unsigned POS_CSRISE  = 8;
  localparam int unsigned POS_OVR     = 3;
  localparam int unsigned POS_TXC     = 2;
  localparam int unsigned POS_DRE     = 1;
  localparam int unsigned POS_RXC     = 0;

  typedef struct packed {
    logic instend;
    logic csrise;
    logic ovr;
    logic txc;
    logic dre;
    logic rxc;
  } flag_set_t;

  // bit position of event flag number idx (0: instruction end, 1: cs rise, 2: overrun)
  function automatic int unsigned evt_pos(int unsigned idx);
    case (idx)
      0:       return POS_INSTEND;
      1:       return POS_CSRISE;
      default: return POS_OVR;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] to_image(flag_set_t f);
    logic [REG_W-1:0] img;
    img              = '0;
    img[POS_INSTEND] = f.instend;
    img[POS_CSRISE]  = f.csrise;
    img[POS_OVR]     = f.ovr;
    img[POS_TXC]     = f.txc;
    img[POS_DRE]     = f.dre;
    img[POS_RXC]     = f.rxc;
    return img;
  endfunction
endpackage

// File: rtl/sif_w1c_flag.sv
module sif_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);
  // hardware set outranks the software clear so no event is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end
endmodule

// File: rtl/sif_rx_status.sv
module sif_rx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_load,
  input  logic rx_read,
  output logic rxc_q,
  output logic ovr_evt
);
  // a second load over unread data is an overrun; a read in the same cycle rescues it
  assign ovr_evt = rx_load & rxc_q & ~rx_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rxc_q <= 1'b0;
    else if (rx_load) rxc_q <= 1'b1;
    else if (rx_read) rxc_q <= 1'b0;
  end
endmodule

// File: rtl/sif_tx_status.sv
module sif_tx_status #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tx_write,
  input  logic             tx_to_shift,
  input  logic             shift_empty,
  input  logic [DLY_W-1:0] dly,
  output logic             dre_q,
  output logic             txc_q
);
  localparam logic [DLY_W-1:0] CNT_ZERO = '0;
  localparam logic [DLY_W-1:0] CNT_ONE  = {{(DLY_W-1){1'b0}}, 1'b1};

  logic             pending_q, pending_d;
  logic             se_d, se_rise;
  logic [DLY_W-1:0] cnt_q;
  logic             armed_q;
  logic             wr_ok;
  logic             dly_done;
  logic             txc_set;

  assign wr_ok = tx_write & enable;

  // a word sits in the transmit register until the shifter takes it
  always_comb begin
    if (!enable)          pending_d = 1'b0;
    else if (tx_write)    pending_d = 1'b1;
    else if (tx_to_shift) pending_d = 1'b0;
    else                  pending_d = pending_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      dre_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      dre_q     <= enable & ~pending_d;
    end
  end

  // guard delay counter, restarted on each rising edge of shift_empty
  assign se_rise = shift_empty & ~se_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_d  <= 1'b0;
      cnt_q <= CNT_ZERO;
    end else begin
      se_d <= shift_empty;
      if (!shift_empty)           cnt_q <= CNT_ZERO;
      else if (se_rise)           cnt_q <= (dly == CNT_ZERO) ? CNT_ZERO : dly - CNT_ONE;
      else if (cnt_q != CNT_ZERO) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign dly_done = se_rise ? (dly == CNT_ZERO) : (cnt_q == CNT_ZERO);
  assign txc_set  = armed_q & ~pending_q & shift_empty & dly_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      txc_q   <= 1'b0;
    end else if (wr_ok) begin
      armed_q <= 1'b1;
      txc_q   <= 1'b0;
    end else if (txc_set) begin
      armed_q <= 1'b0;
      txc_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/sif_intflag.sv
module sif_intflag
  import sif_intflag_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h1C,
  parameter int unsigned      DLY_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  irq_en,
  input  logic              ctl_enable,
  input  logic [DLY_W-1:0]  cfg_xfer_dly,
  input  logic              ev_instr_end,
  input  logic              ev_cs_rise,
  input  logic              rx_load,
  input  logic              rx_read,
  input  logic              tx_write,
  input  logic              tx_to_shift,
  input  logic              shift_empty,
  output logic              irq
);
  logic               sel, wr_hit;
  logic               ovr_evt, rxc, dre, txc;
  logic [NUM_EVT-1:0] evt_set, evt_clr, evt_q;
  flag_set_t          flags;
  logic [REG_W-1:0]   flag_img;

  assign sel    = (bus_addr == REG_OFFSET);
  assign wr_hit = bus_wr & sel;

  sif_rx_status u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_load (rx_load),
    .rx_read (rx_read),
    .rxc_q   (rxc),
    .ovr_evt (ovr_evt)
  );

  sif_tx_status #(.DLY_W(DLY_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (ctl_enable),
    .tx_write    (tx_write),
    .tx_to_shift (tx_to_shift),
    .shift_empty (shift_empty),
    .dly         (cfg_xfer_dly),
    .dre_q       (dre),
    .txc_q       (txc)
  );

  assign evt_set = {ovr_evt, ev_cs_rise, ev_instr_end};

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    localparam int unsigned P = evt_pos(g);
    assign evt_clr[g] = wr_hit & bus_wdata[P];
    sif_w1c_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (evt_set[g]),
      .clr_req (evt_clr[g]),
      .flag_q  (evt_q[g])
    );
  end

  always_comb begin
    flags.instend = evt_q[0];
    flags.csrise  = evt_q[1];
    flags.ovr     = evt_q[2];
    flags.txc     = txc;
    flags.dre     = dre;
    flags.rxc     = rxc;
  end

  assign flag_img  = to_image(flags);
  assign bus_rdata = sel ? flag_img : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flag_img & irq_en);
  end
endmodule

// File: rtl/sif_intflag_chk.sv
module sif_intflag_chk #(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h1C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       irq_en,
  input logic              ctl_enable,
  input logic              ev_instr_end,
  input logic              ev_cs_rise,
  input logic              rx_load,
  input logic              rx_read,
  input logic              tx_write,
  input logic [31:0]       flag_img,
  input logic              irq
);
  logic hit;
  assign hit = bus_wr & (bus_addr == REG_OFFSET);

  AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_instr_end |=> flag_img[10]); // R3
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_wdata[8] && !ev_cs_rise) |=> !flag_img[8]); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_wdata[10] && ev_instr_end) |=> flag_img[10]); // R4
  AST_RXC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> flag_img[0]); // R5
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && flag_img[0] && !rx_read) |=> flag_img[3]); // R6
  AST_DRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> !flag_img[1]); // R7
  AST_TXC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write && ctl_enable) |=> !flag_img[2]); // R8
  AST_RO_RXC: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && flag_img[0] && !rx_read) |=> flag_img[0]); // R9
  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr != REG_OFFSET) && flag_img[10]) |=> flag_img[10]); // R11
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(flag_img & irq_en)))); // R10
endmodule

bind sif_intflag sif_intflag_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .irq_en       (irq_en),
  .ctl_enable   (ctl_enable),
  .ev_instr_end (ev_instr_end),
  .ev_cs_rise   (ev_cs_rise),
  .rx_load      (rx_load),
  .rx_read      (rx_read),
  .tx_write     (tx_write),
  .flag_img     (flag_img),
  .irq          (irq)
);

// File: tb/sif_intflag_tb.sv
module sif_intflag_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFS = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = OFS;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_en = '0;
  logic        ctl_enable = 1'b0;
  logic [7:0]  cfg_xfer_dly = '0;
  logic        ev_instr_end = 1'b0, ev_cs_rise = 1'b0;
  logic        rx_load = 1'b0, rx_read = 1'b0;
  logic        tx_write = 1'b0, tx_to_shift = 1'b0, shift_empty = 1'b1;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sif_intflag u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en),
    .ctl_enable(ctl_enable), .cfg_xfer_dly(cfg_xfer_dly),
    .ev_instr_end(ev_instr_end), .ev_cs_rise(ev_cs_rise),
    .rx_load(rx_load), .rx_read(rx_read), .tx_write(tx_write),
    .tx_to_shift(tx_to_shift), .shift_empty(shift_empty), .irq(irq)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
    bus_addr = OFS;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; bus_wdata = '0; bus_addr = OFS;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(OFS, v);
    chk("R1 flags after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    ev_instr_end = 1'b1; step(); ev_instr_end = 1'b0;
    rd(OFS, v);
    chk("R2 R3 instr end only on bit 10", v, 32'h400);
    wr(OFS, 32'h0);
    rd(OFS, v);
    chk("R3 write 0 keeps bit 10", v, 32'h400);
    wr(OFS, 32'h400);
    rd(OFS, v);
    chk("R3 write 1 clears bit 10", v, 32'h0);
    ev_cs_rise = 1'b1; step(); ev_cs_rise = 1'b0;
    rd(OFS, v);
    chk("R2 R3 cs rise on bit 8", v, 32'h100);
    wr(OFS, 32'hFFFF_FEFF);
    rd(OFS, v);
    chk("R3 clear of other bits keeps bit 8", v, 32'h100);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    rd(8'h18, v);
    chk("R2 other offset reads zero", v, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(OFS, v);
    chk("R11 write elsewhere keeps bit 8", v, 32'h100);
    wr(OFS, 32'h100);
    rd(OFS, v);
    chk("R3 bit 8 cleared", v, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    ev_instr_end = 1'b1; step(); ev_instr_end = 1'b0;
    bus_wdata = 32'h400; bus_wr = 1'b1; ev_instr_end = 1'b1;
    step();
    bus_wr = 1'b0; bus_wdata = '0; ev_instr_end = 1'b0;
    rd(OFS, v);
    chk("R4 set beats clear", v, 32'h400);
    wr(OFS, 32'h400);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    rx_load = 1'b1; step(); rx_load = 1'b0;
    rd(OFS, v);
    chk("R5 load sets bit 0", v, 32'h1);
    rx_read = 1'b1; step(); rx_read = 1'b0;
    rd(OFS, v);
    chk("R5 read clears bit 0", v, 32'h0);
    rx_load = 1'b1; step(); step(); rx_load = 1'b0;
    rd(OFS, v);
    chk("R6 double load sets overrun", v, 32'h9);
    wr(OFS, 32'h8);
    rd(OFS, v);
    chk("R6 overrun cleared by write", v, 32'h1);
    rx_load = 1'b1; rx_read = 1'b1; step(); rx_load = 1'b0; rx_read = 1'b0;
    rd(OFS, v);
    chk("R5 R6 load with read: full, no overrun", v, 32'h1);
  endtask

  task automatic t_dre();
    logic [31:0] v;
    tx_write = 1'b1; step(); tx_write = 1'b0;
    rd(OFS, v);
    chk("R7 disabled: bit 1 low", v & 32'h2, 32'h0);
    ctl_enable = 1'b1; step();
    rd(OFS, v);
    chk("R7 enable sets bit 1", v & 32'h2, 32'h2);
    tx_write = 1'b1; step(); tx_write = 1'b0;
    rd(OFS, v);
    chk("R7 write clears bit 1", v & 32'h2, 32'h0);
    tx_to_shift = 1'b1; step(); tx_to_shift = 1'b0;
    rd(OFS, v);
    chk("R7 transfer sets bit 1", v & 32'h2, 32'h2);
    ctl_enable = 1'b0; step();
    rd(OFS, v);
    chk("R7 disable clears bit 1", v & 32'h2, 32'h0);
    ctl_enable = 1'b1; step();
  endtask

  task automatic t_txc(input logic [7:0] dly);
    logic [31:0] v;
    cfg_xfer_dly = dly;
    tx_write = 1'b1; step(); tx_write = 1'b0;
    rd(OFS, v);
    chk("R8 write clears bit 2", v & 32'h4, 32'h0);
    tx_to_shift = 1'b1; shift_empty = 1'b0; step(); tx_to_shift = 1'b0;
    step();
    rd(OFS, v);
    chk("R8 shifter busy: bit 2 low", v & 32'h4, 32'h0);
    shift_empty = 1'b1;
    for (int j = 0; j < int'(dly); j++) begin
      step();
      rd(OFS, v);
      chk("R8 during delay bit 2 low", v & 32'h4, 32'h0);
    end
    step();
    rd(OFS, v);
    chk("R8 after delay bit 2 high", v & 32'h4, 32'h4);
  endtask

  task automatic t_ro();
    logic [31:0] v0, v1;
    rx_load = 1'b1; step(); rx_load = 1'b0;
    rd(OFS, v0);
    chk("R9 precondition bits 2:0 set", v0 & 32'h7, 32'h7);
    wr(OFS, 32'h7);
    rd(OFS, v1);
    chk("R9 write to bits 2:0 ignored", v1, v0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    irq_en = 32'h400; step();
    chk("R10 irq low with masked flags off", {31'b0, irq}, 32'h0);
    ev_instr_end = 1'b1; step(); ev_instr_end = 1'b0;
    chk("R10 irq registered one cycle later", {31'b0, irq}, 32'h0);
    step();
    chk("R10 irq high", {31'b0, irq}, 32'h1);
    irq_en = 32'h0; step(); step();
    chk("R10 mask removes irq", {31'b0, irq}, 32'h0);
    irq_en = 32'h400; step(); step();
    chk("R10 mask restores irq", {31'b0, irq}, 32'h1);
    wr(OFS, 32'h400);
    step();
    chk("R10 clear drops irq", {31'b0, irq}, 32'h0);
    rd(OFS, v);
    chk("R3 bit 10 cleared", v & 32'h400, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_events();
    t_addr();
    t_set_wins();
    t_rx();
    rx_read = 1'b1; step(); rx_read = 1'b0;
    t_dre();
    t_txc(8'd3);
    t_txc(8'd0);
    t_txc(8'd1);
    t_ro();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule